// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block gathers interrupt lines from peripherals and decides, for every CPU interface, which lines that interface should currently see as pending. Software programs it through a word-addressed register port. A sideband field names the CPU that issues each access. The bank holds a global forwarding switch, enable bits changed only by write-one-to-set and write-one-to-clear words, an 8-bit priority per line, an 8-bit CPU routing mask per shared line, a trigger-sense field per line and a read-only size register.

IDs 0 to 31 are private. Every CPU interface has its own input lines, enable bits, pending bits and active bits for these IDs. The requesting-CPU field picks which copy a register access reaches. IDs from 32 upward are shared. Each one is routed to the CPU interfaces whose bits are set in its routing mask. The CPU interfaces do arbitration and acknowledge handling. They report back to this block with per-CPU acknowledge and completion strobes that carry an ID. The block drives one pending bit for each pair of CPU interface and ID, plus the priority bytes, so that a downstream arbiter can use them.

Register words (word address): 0x00 control, 0x01 size, 0x04+w enable-set, 0x08+w enable-clear, 0x10+k priority, 0x30+k routing, 0x50+k trigger sense. Unmapped words read 0.

Top module: `irq_distributor`

## Requirements
- R1: After reset the control bit, every enable, every priority byte and every routing mask read 0, and every shared trigger field reads 2'b00. All pending outputs are 0.
- R2: Word 0x01 is read-only. Bits [4:0] hold N = NUM_IRQ/32 - 1, so that the line count is (N+1)*32 capped at 1020. Bits [31:5] read 0.
- R3: At word 0x04+w a 1 in bit b sets the enable of ID 32w+b, and a 1 at word 0x08+w clears it. Bits written as 0 change nothing. Both words read back the current enables.
- R4: For IDs 0–31, enable, pending and active state exist once per CPU. Word 0 of the enable words and the acknowledge and completion strobes reach only the copy of the CPU that issues them. Other CPUs' copies are unaffected.
- R5: Routing word 0x30+k holds the mask of ID 4k+j in bits [8j+7:8j]. Bit c routes the line to CPU c. Mask bits at or above NUM_CPU are not stored and read 0.
- R6: Routing words for IDs 0–31 (k < 8) ignore writes. Every byte reads as the requesting CPU's own bit, 1 << cpu.
- R7: Trigger word 0x50+k holds the field of ID 16k+j in bits [2j+1:2j]. 2'b10 means rising edge and 2'b00 means level-high; bit 2j reads 0. Fields for IDs 0–15 are fixed at 2'b10 and ignore writes.
- R8: Priority word 0x10+k holds the byte of ID 4k+j in bits [8j+7:8j]. The byte can be read and written and is driven on prio_o[8i+7:8i].
- R9: A level-high line is pending from the clock edge after its input rises until the clock edge after it falls.
- R10: An edge line becomes pending on a rising input and stays pending after the input falls. An acknowledge of that ID clears pending and sets active.
- R11: cpu_pend[c*NUM_IRQ+i] is 1 exactly when the control bit is set and line i is enabled, pending and not active. For a private line this uses CPU c's copy; for a shared line bit c of the routing mask must also be set. A completion strobe clears active.
- R12: With the control bit at 0 every pending output is 0, while edge pending state is kept. Setting the bit again forwards that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_vld | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | CPU_W | Number of the requesting CPU |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| spi_in | input | NUM_IRQ-32 | Shared lines, bit i is ID 32+i |
| ppi_in | input | NUM_CPU*32 | Private lines, bit c*32+b is ID b of CPU c |
| ack_vld | input | NUM_CPU | Acknowledge strobe per CPU |
| ack_id | input | NUM_CPU*ID_W | Acknowledged ID per CPU |
| eoi_vld | input | NUM_CPU | Completion strobe per CPU |
| eoi_id | input | NUM_CPU*ID_W | Completed ID per CPU |
| cpu_pend | output | NUM_CPU*NUM_IRQ | Pending vector per CPU interface |
| prio_o | output | NUM_IRQ*8 | Priority byte per ID |

## Verification
Assertions check these properties on every cycle: enables change only in a cycle with a set or clear strobe, an edge line's pending bit stays set until an acknowledge, active rises only after an acknowledge, the outputs are silent while forwarding is off, private routing reads are one-hot, and the size field decodes to NUM_IRQ. Only the directed scenarios can show the rest. These are: that write-zero bits really leave enables alone, that one CPU's banked state is untouched by another CPU, the routing masks and the fixed fields, the one-cycle latency of level lines, and that a held edge comes back after completion and after forwarding is turned on again.

// File: rtl/irqd_pkg.sv
`timescale 1ns/1ps
package irqd_pkg;
  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_TYPE  = 8'h01;
  localparam logic [7:0] A_ENSET = 8'h04;
  localparam logic [7:0] A_ENCLR = 8'h08;
  localparam logic [7:0] A_PRIO  = 8'h10;
  localparam logic [7:0] A_TGT   = 8'h30;
  localparam logic [7:0] A_CFG   = 8'h50;

  // size code: number of 32-line groups minus one
  function automatic logic [4:0] type_code(input int lines);
    return 5'((lines + 31) / 32 - 1);
  endfunction

  // inverse of the size code, capped at the architectural maximum
  function automatic int lines_from_code(input logic [4:0] n);
    int l;
    l = (int'(n) + 1) * 32;
    return (l > 1020) ? 1020 : l;
  endfunction

  function automatic logic [7:0] at(input logic [7:0] base, input int k);
    return base + 8'(k);
  endfunction
endpackage

// File: rtl/irqd_line.sv
`timescale 1ns/1ps
module irqd_line (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic edge_mode,
  input  logic en_set,
  input  logic en_clr,
  input  logic ack,
  input  logic eoi,
  output logic en_o,
  output logic pend_o,
  output logic act_o
);
  logic in_q, en_q, pend_q, act_q;
  logic rise;

  assign rise = line_in & ~in_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q <= 1'b0; en_q <= 1'b0; pend_q <= 1'b0; act_q <= 1'b0;
    end else begin
      in_q <= line_in;
      if (en_set)      en_q <= 1'b1;
      else if (en_clr) en_q <= 1'b0;
      if (edge_mode) begin
        if (rise)     pend_q <= 1'b1;
        else if (ack) pend_q <= 1'b0;
      end else begin
        pend_q <= line_in;
      end
      if (ack)      act_q <= 1'b1;
      else if (eoi) act_q <= 1'b0;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign act_o  = act_q;

  // R3: enable moves only under a set or clear strobe
  p_en_by_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_q) |-> $past(en_set || en_clr));
  // R10: a latched edge survives until acknowledged
  p_edge_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(edge_mode) && edge_mode && $past(pend_q) && !$past(ack)) |-> pend_q);
  // R11: active is only entered by an acknowledge
  p_act_from_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> $past(ack));
endmodule

// File: rtl/irqd_cfg.sv
`timescale 1ns/1ps
module irqd_cfg #(
  parameter int NUM_CPU = 4,
  parameter int NUM_IRQ = 64,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int NSH   = NUM_IRQ - 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [7:0]             addr,
  input  logic [31:0]            wdata,
  input  logic [CPU_W-1:0]       rd_cpu,
  output logic                   gen_o,
  output logic [NUM_IRQ*8-1:0]   prio_o,
  output logic [NSH*NUM_CPU-1:0] tgt_o,
  output logic [NUM_IRQ-1:0]     edge_o,
  output logic [31:0]            rdata_o
);
  import irqd_pkg::*;
  localparam int PW = NUM_IRQ / 4;
  localparam int CW = NUM_IRQ / 16;

  logic                gen_q;
  logic [7:0]          prio_q [NUM_IRQ];
  logic [NUM_CPU-1:0]  tgt_q  [NSH];
  logic [NUM_IRQ-17:0] edge_sh;
  logic [7:0]          own;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q   <= 1'b0;
      edge_sh <= '0;
      for (int i = 0; i < NUM_IRQ; i++) prio_q[i] <= '0;
      for (int i = 0; i < NSH; i++)     tgt_q[i]  <= '0;
    end else if (wr) begin
      if (addr == A_CTRL) gen_q <= wdata[0];
      for (int k = 0; k < PW; k++)
        if (addr == at(A_PRIO, k))
          for (int j = 0; j < 4; j++) prio_q[4*k+j] <= wdata[8*j +: 8];
      for (int k = 8; k < PW; k++)
        if (addr == at(A_TGT, k))
          for (int j = 0; j < 4; j++) tgt_q[4*k+j-32] <= wdata[8*j +: NUM_CPU];
      for (int k = 1; k < CW; k++)
        if (addr == at(A_CFG, k))
          for (int j = 0; j < 16; j++) edge_sh[16*k+j-16] <= wdata[2*j+1];
    end
  end

  assign own = 8'(1) << rd_cpu;

  always_comb begin
    rdata_o = '0;
    if (addr == A_CTRL) rdata_o[0] = gen_q;
    if (addr == A_TYPE) rdata_o[4:0] = type_code(NUM_IRQ);
    for (int k = 0; k < PW; k++)
      if (addr == at(A_PRIO, k))
        for (int j = 0; j < 4; j++) rdata_o[8*j +: 8] = prio_q[4*k+j];
    for (int k = 0; k < 8; k++)
      if (addr == at(A_TGT, k))
        for (int j = 0; j < 4; j++) rdata_o[8*j +: 8] = own;
    for (int k = 8; k < PW; k++)
      if (addr == at(A_TGT, k))
        for (int j = 0; j < 4; j++) rdata_o[8*j +: NUM_CPU] = tgt_q[4*k+j-32];
    if (addr == A_CFG)
      for (int j = 0; j < 16; j++) rdata_o[2*j+1] = 1'b1;
    for (int k = 1; k < CW; k++)
      if (addr == at(A_CFG, k))
        for (int j = 0; j < 16; j++) rdata_o[2*j+1] = edge_sh[16*k+j-16];
  end

  assign gen_o  = gen_q;
  assign edge_o = {edge_sh, 16'hFFFF};
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
    assign prio_o[8*i +: 8] = prio_q[i];
  end
  for (genvar i = 0; i < NSH; i++) begin : g_tgt
    assign tgt_o[i*NUM_CPU +: NUM_CPU] = tgt_q[i];
  end
endmodule

// File: rtl/irqd_fwd.sv
`timescale 1ns/1ps
module irqd_fwd #(
  parameter int NUM_CPU = 4,
  parameter int NUM_IRQ = 64,
  localparam int NSH = NUM_IRQ - 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       gen,
  input  logic [NUM_CPU*32-1:0]      p_en,
  input  logic [NUM_CPU*32-1:0]      p_pend,
  input  logic [NUM_CPU*32-1:0]      p_act,
  input  logic [NSH-1:0]             s_en,
  input  logic [NSH-1:0]             s_pend,
  input  logic [NSH-1:0]             s_act,
  input  logic [NSH*NUM_CPU-1:0]     s_tgt,
  output logic [NUM_CPU*NUM_IRQ-1:0] pend_o
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar i = 0; i < 32; i++) begin : g_priv
      assign pend_o[c*NUM_IRQ+i] = gen & p_en[c*32+i] & p_pend[c*32+i] & ~p_act[c*32+i];
    end
    for (genvar i = 0; i < NSH; i++) begin : g_shr
      assign pend_o[c*NUM_IRQ+32+i] = gen & s_en[i] & s_pend[i] & ~s_act[i]
                                      & s_tgt[i*NUM_CPU+c];
    end
  end

  // R12: nothing is forwarded while the global switch is off
  p_off_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !gen |-> (pend_o == '0));
endmodule

// File: rtl/irq_distributor.sv
`timescale 1ns/1ps
module irq_distributor #(
  parameter int NUM_CPU = 4,
  parameter int NUM_IRQ = 64,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int ID_W  = $clog2(NUM_IRQ),
  localparam int NSH   = NUM_IRQ - 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_vld,
  input  logic                       bus_wr,
  input  logic [7:0]                 bus_addr,
  input  logic [31:0]                bus_wdata,
  input  logic [CPU_W-1:0]           bus_cpu,
  output logic [31:0]                bus_rdata,
  input  logic [NSH-1:0]             spi_in,
  input  logic [NUM_CPU*32-1:0]      ppi_in,
  input  logic [NUM_CPU-1:0]         ack_vld,
  input  logic [NUM_CPU*ID_W-1:0]    ack_id,
  input  logic [NUM_CPU-1:0]         eoi_vld,
  input  logic [NUM_CPU*ID_W-1:0]    eoi_id,
  output logic [NUM_CPU*NUM_IRQ-1:0] cpu_pend,
  output logic [NUM_IRQ*8-1:0]       prio_o
);
  import irqd_pkg::*;
  localparam int NW = NUM_IRQ / 32;

  logic                   wr;
  logic                   gen;
  logic [NSH*NUM_CPU-1:0] s_tgt;
  logic [NUM_IRQ-1:0]     edge_v;
  logic [31:0]            cfg_rd, en_rd;
  logic [NUM_CPU*32-1:0]  p_set, p_clr, p_ack, p_eoi, p_en, p_pend, p_act;
  logic [NSH-1:0]         s_set, s_clr, s_ack, s_eoi, s_en, s_pend, s_act;

  assign wr = bus_vld & bus_wr;

  irqd_cfg #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(wr), .addr(bus_addr), .wdata(bus_wdata),
    .rd_cpu(bus_cpu), .gen_o(gen), .prio_o(prio_o), .tgt_o(s_tgt),
    .edge_o(edge_v), .rdata_o(cfg_rd));

  // strobe decode: banked word 0 selected by requesting CPU
  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int b = 0; b < 32; b++) begin
        p_set[c*32+b] = wr && bus_addr == A_ENSET && bus_cpu == CPU_W'(c) && bus_wdata[b];
        p_clr[c*32+b] = wr && bus_addr == A_ENCLR && bus_cpu == CPU_W'(c) && bus_wdata[b];
        p_ack[c*32+b] = ack_vld[c] && ack_id[c*ID_W +: ID_W] == ID_W'(b);
        p_eoi[c*32+b] = eoi_vld[c] && eoi_id[c*ID_W +: ID_W] == ID_W'(b);
      end
    end
    for (int i = 0; i < NSH; i++) begin
      s_set[i] = wr && bus_addr == at(A_ENSET, (i+32)/32) && bus_wdata[(i+32)%32];
      s_clr[i] = wr && bus_addr == at(A_ENCLR, (i+32)/32) && bus_wdata[(i+32)%32];
      s_ack[i] = 1'b0;
      s_eoi[i] = 1'b0;
      for (int c = 0; c < NUM_CPU; c++) begin
        s_ack[i] = s_ack[i] | (ack_vld[c] && ack_id[c*ID_W +: ID_W] == ID_W'(i+32));
        s_eoi[i] = s_eoi[i] | (eoi_vld[c] && eoi_id[c*ID_W +: ID_W] == ID_W'(i+32));
      end
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
    for (genvar b = 0; b < 32; b++) begin : g_line
      irqd_line u_line (
        .clk(clk), .rst_n(rst_n), .line_in(ppi_in[c*32+b]), .edge_mode(edge_v[b]),
        .en_set(p_set[c*32+b]), .en_clr(p_clr[c*32+b]), .ack(p_ack[c*32+b]),
        .eoi(p_eoi[c*32+b]), .en_o(p_en[c*32+b]), .pend_o(p_pend[c*32+b]),
        .act_o(p_act[c*32+b]));
    end
  end

  for (genvar i = 0; i < NSH; i++) begin : g_shared
    irqd_line u_line (
      .clk(clk), .rst_n(rst_n), .line_in(spi_in[i]), .edge_mode(edge_v[32+i]),
      .en_set(s_set[i]), .en_clr(s_clr[i]), .ack(s_ack[i]), .eoi(s_eoi[i]),
      .en_o(s_en[i]), .pend_o(s_pend[i]), .act_o(s_act[i]));
  end

  irqd_fwd #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_fwd (
    .clk(clk), .rst_n(rst_n), .gen(gen), .p_en(p_en), .p_pend(p_pend),
    .p_act(p_act), .s_en(s_en), .s_pend(s_pend), .s_act(s_act),
    .s_tgt(s_tgt), .pend_o(cpu_pend));

  // enable readback, banked for word 0
  always_comb begin
    en_rd = '0;
    for (int w = 0; w < NW; w++)
      if (bus_addr == at(A_ENSET, w) || bus_addr == at(A_ENCLR, w)) begin
        if (w == 0) en_rd = p_en[int'(bus_cpu)*32 +: 32];
        else        en_rd = s_en[(w-1)*32 +: 32];
      end
  end

  assign bus_rdata = cfg_rd | en_rd;

  // R6: private routing reads name exactly one CPU per byte
  p_tgt_priv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && !bus_wr && bus_addr >= A_TGT && bus_addr < at(A_TGT, 8))
      |-> ($countones(bus_rdata[7:0]) == 1));
  // R2: size word decodes back to the built line count
  p_type_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_TYPE) |-> (lines_from_code(bus_rdata[4:0]) == NUM_IRQ
                              && bus_rdata[31:5] == '0));
endmodule

// File: tb/irq_distributor_tb.sv
`timescale 1ns/1ps
module irq_distributor_tb;
  localparam int NC = 4;
  localparam int NI = 64;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_vld = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0] bus_cpu = '0;
  logic [31:0] bus_rdata;
  logic [NI-33:0] spi_in = '0;
  logic [NC*32-1:0] ppi_in = '0;
  logic [NC-1:0] ack_vld = '0, eoi_vld = '0;
  logic [NC*IW-1:0] ack_id = '0, eoi_id = '0;
  logic [NC*NI-1:0] cpu_pend;
  logic [NI*8-1:0] prio_o;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  irq_distributor #(.NUM_CPU(NC), .NUM_IRQ(NI)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
    .bus_rdata(bus_rdata), .spi_in(spi_in), .ppi_in(ppi_in),
    .ack_vld(ack_vld), .ack_id(ack_id), .eoi_vld(eoi_vld), .eoi_id(eoi_id),
    .cpu_pend(cpu_pend), .prio_o(prio_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr32(input logic [1:0] cpu, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_vld = 1'b1; bus_wr = 1'b1; bus_cpu = cpu; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_vld = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd32(input logic [1:0] cpu, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_vld = 1'b1; bus_wr = 1'b0; bus_cpu = cpu; bus_addr = a;
    #1 d = bus_rdata;
    bus_vld = 1'b0;
  endtask

  task automatic strobe_ack(input int cpu, input int id);
    @(negedge clk);
    ack_vld[cpu] = 1'b1; ack_id[cpu*IW +: IW] = IW'(id);
    @(negedge clk);
    ack_vld[cpu] = 1'b0;
  endtask

  task automatic strobe_eoi(input int cpu, input int id);
    @(negedge clk);
    eoi_vld[cpu] = 1'b1; eoi_id[cpu*IW +: IW] = IW'(id);
    @(negedge clk);
    eoi_vld[cpu] = 1'b0;
  endtask

  function automatic logic pend_of(input int cpu, input int id);
    return cpu_pend[cpu*NI + id];
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 pend out", 32'(cpu_pend == '0), 32'd1);
    rd32(0, 8'h00, d); chk("R1 ctrl", d, 32'h0);
    rd32(0, 8'h05, d); chk("R1 enables", d, 32'h0);
    rd32(0, 8'h13, d); chk("R1 prio", d, 32'h0);
    rd32(0, 8'h51, d); chk("R1 cfg shared", d, 32'h0);
  endtask

  task automatic t_type;
    logic [31:0] d;
    rd32(0, 8'h01, d); chk("R2 type", d, 32'(NI/32 - 1));
    wr32(0, 8'h01, 32'hFFFF_FFFF);
    rd32(0, 8'h01, d); chk("R2 type ro", d, 32'(NI/32 - 1));
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr32(0, 8'h04 + 8'd1, 32'h5);
    rd32(0, 8'h05, d); chk("R3 set", d, 32'h5);
    wr32(0, 8'h05, 32'h2);
    rd32(0, 8'h05, d); chk("R3 zeros keep", d, 32'h7);
    wr32(0, 8'h09, 32'h4);
    rd32(0, 8'h09, d); chk("R3 clear", d, 32'h3);
  endtask

  task automatic t_bank;
    logic [31:0] d;
    wr32(1, 8'h04, 32'h0001_0000);
    rd32(1, 8'h04, d); chk("R4 own bank", d, 32'h0001_0000);
    rd32(2, 8'h04, d); chk("R4 other bank", d, 32'h0);
  endtask

  task automatic t_target;
    logic [31:0] d;
    wr32(0, 8'h38, 32'hFF03_0201);
    rd32(0, 8'h38, d); chk("R5 mask", d, 32'h0F03_0201);
    rd32(2, 8'h30, d); chk("R6 own cpu2", d, 32'h0404_0404);
    wr32(3, 8'h31, 32'h0);
    rd32(3, 8'h31, d); chk("R6 ro cpu3", d, 32'h0808_0808);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    wr32(0, 8'h50, 32'h0);
    rd32(0, 8'h50, d); chk("R7 fixed", d, 32'hAAAA_AAAA);
    wr32(0, 8'h51, 32'hFFFF_FFFF);
    rd32(0, 8'h51, d); chk("R7 bit0 zero", d, 32'hAAAA_AAAA);
    wr32(0, 8'h51, 32'h0);
    wr32(0, 8'h52, 32'h2);
    rd32(0, 8'h52, d); chk("R7 id32 edge", d, 32'h2);
  endtask

  task automatic t_prio;
    logic [31:0] d;
    wr32(0, 8'h12, 32'h1122_3344);
    rd32(0, 8'h12, d); chk("R8 prio rd", d, 32'h1122_3344);
    chk("R8 prio out id8", 32'(prio_o[8*8 +: 8]), 32'h44);
    chk("R8 prio out id11", 32'(prio_o[11*8 +: 8]), 32'h11);
  endtask

  task automatic t_level;
    wr32(0, 8'h00, 32'h1);
    @(negedge clk); spi_in[1] = 1'b1;   // ID 33, level, routed to CPU1
    chk("R9 not yet", 32'(pend_of(1, 33)), 32'd0);
    @(negedge clk);
    chk("R9 level cpu1", 32'(pend_of(1, 33)), 32'd1);
    chk("R11 not routed cpu0", 32'(pend_of(0, 33)), 32'd0);
    spi_in[1] = 1'b0;
    @(negedge clk);
    chk("R9 level drop", 32'(pend_of(1, 33)), 32'd0);
  endtask

  task automatic t_edge;
    @(negedge clk); spi_in[0] = 1'b1;   // ID 32, edge, routed to CPU0
    @(negedge clk); spi_in[0] = 1'b0;
    @(negedge clk);
    chk("R10 edge held", 32'(pend_of(0, 32)), 32'd1);
    strobe_ack(0, 32);
    chk("R10 ack clears", 32'(pend_of(0, 32)), 32'd0);
    @(negedge clk); spi_in[0] = 1'b1;
    @(negedge clk); spi_in[0] = 1'b0;
    chk("R11 active masks", 32'(pend_of(0, 32)), 32'd0);
    strobe_eoi(0, 32);
    chk("R11 eoi reveals", 32'(pend_of(0, 32)), 32'd1);
  endtask

  task automatic t_gate;
    wr32(0, 8'h00, 32'h0);
    chk("R12 off silent", 32'(cpu_pend == '0), 32'd1);
    wr32(0, 8'h00, 32'h1);
    chk("R12 resume", 32'(pend_of(0, 32)), 32'd1);
    strobe_ack(0, 32);
    strobe_eoi(0, 32);
    chk("R10 done", 32'(pend_of(0, 32)), 32'd0);
  endtask

  task automatic t_private;
    wr32(2, 8'h04, 32'h0010_0000);      // CPU2 enables its ID 20
    @(negedge clk);
    ppi_in[2*32+20] = 1'b1; ppi_in[1*32+20] = 1'b1;
    @(negedge clk);
    chk("R4 cpu2 private", 32'(pend_of(2, 20)), 32'd1);
    chk("R4 cpu1 disabled", 32'(pend_of(1, 20)), 32'd0);
    strobe_ack(2, 20);
    chk("R11 private active", 32'(pend_of(2, 20)), 32'd0);
    wr32(1, 8'h04, 32'h0010_0000);
    chk("R4 cpu1 not active", 32'(pend_of(1, 20)), 32'd1);
    strobe_eoi(2, 20);
    chk("R11 private eoi", 32'(pend_of(2, 20)), 32'd1);
    ppi_in = '0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_type();
    t_enable();
    t_bank();
    t_target();
    t_cfg();
    t_prio();
    t_level();
    t_edge();
    t_gate();
    t_private();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule